// File: doc/BRIEF.md
# RGB to YCbCr Tile Converter

This block takes a stream of 24-bit RGB pixels, one per clock with a valid flag, and produces one luma byte and two chroma bytes per pixel. Each component is a weighted sum of the three colour channels. Chroma carries a mid-scale offset so that it fits an unsigned byte. The arithmetic is fixed point, with coefficients scaled by 2^14. Each sum is rounded to nearest and then saturated to the byte range.

Pixels arrive in raster order as 16x16 tiles. Every result carries a tile-local write address, so a downstream store can drop the Y, Cb and Cr bytes into three separate 256-entry component planes. A one-cycle marker travels with the last pixel of each tile. The marker tells the next stage that all three planes are complete.

The converter has three register stages and no stall path. A pixel accepted on one clock edge appears at the outputs after the third rising edge, counting the edge that accepted it.

Top module: `ycc_tile_converter`

## Requirements
- R1: out_y equals floor((4897*R + 9611*G + 1876*B + 8192) / 16384), clamped to 0..255. For example, white (255,255,255) gives 255, and pure green gives 150.
- R2: out_cb equals floor((-2764*R - 5426*G + 8192*B + 128*16384 + 8192) / 16384), clamped to 0..255. For example, black gives 128, and pure red gives 85.
- R3: out_cr equals floor((8192*R - 6853*G - 1337*B + 128*16384 + 8192) / 16384), clamped to 0..255. For example, pure green gives 21, and pure blue gives 107.
- R4: A result above 255 is saturated to 255 and does not wrap. Pure blue gives Cb 255, and pure red gives Cr 255. A result below 0 would be forced to 0.
- R5: out_valid is in_valid delayed by exactly three rising edges. The three component bytes presented with out_valid belong to the pixel accepted three edges earlier.
- R6: While rst_n is low, out_valid and out_tile_done are 0. After reset, the first accepted pixel is given address 0.
- R7: out_addr is the count of valid pixels accepted before this one since reset, modulo 256. Bits [7:4] are the row and bits [3:0] are the column within the tile. Cycles with in_valid low do not advance the count.
- R8: out_tile_done is high for exactly the output cycles whose out_valid is 1 and whose out_addr is 255, and it is low at all other times.
- R9: For any grey input (R = G = B = v), out_y is v and both chroma outputs are 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present on in_r/in_g/in_b this cycle |
| in_r | input | 8 | Red channel, unsigned |
| in_g | input | 8 | Green channel, unsigned |
| in_b | input | 8 | Blue channel, unsigned |
| out_valid | output | 1 | Result bytes and address are valid |
| out_y | output | 8 | Luma byte |
| out_cb | output | 8 | Blue-difference chroma byte |
| out_cr | output | 8 | Red-difference chroma byte |
| out_addr | output | 8 | Tile-local plane address, row in [7:4], column in [3:0] |
| out_tile_done | output | 1 | Marks the last pixel of a 16x16 tile |

## Verification
The checker watches four properties on every cycle. It checks the exact three-edge valid delay and the step-by-one address sequence with its wrap from 255 to 0. It checks that the tile marker appears only on address 255 and only with a valid output. It also checks the grey-axis identity, where luma passes the input through and both chroma outputs sit at 128.

Only the bench scenarios can show that the coefficients themselves are right. They do this through saturated primaries, mixed colours, a dense tile and a tile with idle gaps. The bench also shows that idle cycles leave the address alone and that reset restarts the tile count.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    // Fractional bits of the fixed-point coefficients.
    localparam int FRAC_BITS = 14;

    // Number of output components, and number of input channels per component.
    localparam int NUM_COMP = 3;
    localparam int NUM_CHAN = 3;

    // Component indices.
    localparam int COMP_Y  = 0;
    localparam int COMP_CB = 1;
    localparam int COMP_CR = 2;

    // Signed coefficient for a given component and channel (channel 0=R, 1=G, 2=B).
    // Values are the real weights scaled by 2^FRAC_BITS and rounded.
    function automatic int coef(input int comp, input int chan);
        int k;
        k = 0;
        case (comp)
            COMP_Y: begin
                case (chan)
                    0: k = 4897;
                    1: k = 9611;
                    default: k = 1876;
                endcase
            end
            COMP_CB: begin
                case (chan)
                    0: k = -2764;
                    1: k = -5426;
                    default: k = 8192;
                endcase
            end
            default: begin
                case (chan)
                    0: k = 8192;
                    1: k = -6853;
                    default: k = -1337;
                endcase
            end
        endcase
        return k;
    endfunction

    // Nonzero for components that carry the mid-scale offset.
    function automatic bit has_offset(input int comp);
        return comp != COMP_Y;
    endfunction

endpackage

// File: rtl/ycc_lane.sv
module ycc_lane #(
    parameter int PIX_W = 8,
    parameter int FRAC  = 14,
    parameter int ACC_W = 26,
    parameter int K_R   = 0,
    parameter int K_G   = 0,
    parameter int K_B   = 0,
    parameter bit USE_OFFSET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] r,
    input  logic [PIX_W-1:0] g,
    input  logic [PIX_W-1:0] b,
    output logic [PIX_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] KS_R = ACC_W'(K_R);
    localparam logic signed [ACC_W-1:0] KS_G = ACC_W'(K_G);
    localparam logic signed [ACC_W-1:0] KS_B = ACC_W'(K_B);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MID  = ACC_W'(1) <<< (PIX_W - 1 + FRAC);
    localparam logic signed [ACC_W-1:0] BIAS = USE_OFFSET ? (MID + HALF) : HALF;
    localparam logic signed [ACC_W-1:0] TOPV = (ACC_W'(1) <<< PIX_W) - ACC_W'(1);
    localparam int                      PADW = ACC_W - PIX_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] prod_r;
        logic signed [ACC_W-1:0] prod_g;
        logic signed [ACC_W-1:0] prod_b;
        logic signed [ACC_W-1:0] acc;
        logic [PIX_W-1:0]        res;
    } lane_t;

    lane_t s_d, s_q;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        s_d = s_q;
        // Stage 1: three products.
        s_d.prod_r = $signed({{PADW{1'b0}}, r}) * KS_R;
        s_d.prod_g = $signed({{PADW{1'b0}}, g}) * KS_G;
        s_d.prod_b = $signed({{PADW{1'b0}}, b}) * KS_B;
        // Stage 2: sum, offset and rounding bias.
        s_d.acc = s_q.prod_r + s_q.prod_g + s_q.prod_b + BIAS;
        // Stage 3: drop fraction, saturate.
        scaled = s_q.acc >>> FRAC;
        if (scaled < 0) begin
            s_d.res = '0;
        end else if (scaled > TOPV) begin
            s_d.res = '1;
        end else begin
            s_d.res = scaled[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign res = s_q.res;

endmodule

// File: rtl/ycc_tile_index.sv
module ycc_tile_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] count;
    } idx_t;

    idx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (advance) begin
            s_d.count = s_q.count + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx = s_q.count;

endmodule

// File: rtl/ycc_tile_converter.sv
module ycc_tile_converter #(
    parameter int PIX_W     = 8,
    parameter int TILE_SIDE = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [PIX_W-1:0]                  in_r,
    input  logic [PIX_W-1:0]                  in_g,
    input  logic [PIX_W-1:0]                  in_b,
    output logic                              out_valid,
    output logic [PIX_W-1:0]                  out_y,
    output logic [PIX_W-1:0]                  out_cb,
    output logic [PIX_W-1:0]                  out_cr,
    output logic [2*$clog2(TILE_SIDE)-1:0]    out_addr,
    output logic                              out_tile_done
);

    import ycc_pkg::*;

    localparam int SIDE_W = $clog2(TILE_SIDE);
    localparam int IDX_W  = 2 * SIDE_W;
    localparam int FRAC   = FRAC_BITS;
    localparam int ACC_W  = PIX_W + FRAC + 4;
    localparam int STAGES = 3;

    // Control pipeline that runs beside the arithmetic lanes.
    typedef struct packed {
        logic [STAGES-1:0]            vld;
        logic [STAGES-1:0][IDX_W-1:0] addr;
        logic                         done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [PIX_W-1:0]  comp_res [NUM_COMP];

    ycc_tile_index #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .idx     (cur_idx)
    );

    for (genvar gi = 0; gi < NUM_COMP; gi++) begin : g_lane
        ycc_lane #(
            .PIX_W      (PIX_W),
            .FRAC       (FRAC),
            .ACC_W      (ACC_W),
            .K_R        (coef(gi, 0)),
            .K_G        (coef(gi, 1)),
            .K_B        (coef(gi, 2)),
            .USE_OFFSET (has_offset(gi))
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .r     (in_r),
            .g     (in_g),
            .b     (in_b),
            .res   (comp_res[gi])
        );
    end

    always_comb begin
        c_d = c_q;
        c_d.vld[0]  = in_valid;
        c_d.addr[0] = cur_idx;
        for (int s = 1; s < STAGES; s++) begin
            c_d.vld[s]  = c_q.vld[s-1];
            c_d.addr[s] = c_q.addr[s-1];
        end
        c_d.done = c_q.vld[STAGES-2] && (c_q.addr[STAGES-2] == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_valid     = c_q.vld[STAGES-1];
    assign out_addr      = c_q.addr[STAGES-1];
    assign out_tile_done = c_q.done;
    assign out_y         = comp_res[COMP_Y];
    assign out_cb        = comp_res[COMP_CB];
    assign out_cr        = comp_res[COMP_CR];

endmodule

// File: rtl/ycc_tile_converter_chk.sv
module ycc_tile_converter_chk #(
    parameter int PIX_W = 8,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_r,
    input logic [PIX_W-1:0] in_g,
    input logic [PIX_W-1:0] in_b,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cb,
    input logic [PIX_W-1:0] out_cr,
    input logic [IDX_W-1:0] out_addr,
    input logic             out_tile_done
);

    localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

    logic [1:0]       warm_q;
    logic             seen_q;
    logic [IDX_W-1:0] last_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q      <= '0;
            seen_q      <= 1'b0;
            last_addr_q <= '0;
        end else begin
            if (warm_q != 2'd3) begin
                warm_q <= warm_q + 2'd1;
            end
            if (out_valid) begin
                // R7: addresses step by one, first one is zero
                if (seen_q) begin
                    p_addr_step_r7: assert (out_addr == last_addr_q + IDX_W'(1))
                        else $error("address did not step by one");
                end else begin
                    p_addr_first_r7: assert (out_addr == '0)
                        else $error("first address after reset not zero");
                end
                seen_q      <= 1'b1;
                last_addr_q <= out_addr;
            end
        end
    end

    p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_done_only_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_tile_done == (out_valid && (out_addr == '1)));

    p_grey_axis_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && $past(in_valid, 3)
         && ($past(in_r, 3) == $past(in_g, 3)) && ($past(in_g, 3) == $past(in_b, 3)))
        |-> ((out_y == $past(in_r, 3)) && (out_cb == MID) && (out_cr == MID)));

endmodule

bind ycc_tile_converter ycc_tile_converter_chk #(
    .PIX_W (PIX_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_r          (in_r),
    .in_g          (in_g),
    .in_b          (in_b),
    .out_valid     (out_valid),
    .out_y         (out_y),
    .out_cb        (out_cb),
    .out_cr        (out_cr),
    .out_addr      (out_addr),
    .out_tile_done (out_tile_done)
);

// File: tb/ycc_tile_converter_tb.sv
module ycc_tile_converter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_r, in_g, in_b;
    logic       out_valid;
    logic [7:0] out_y, out_cb, out_cr;
    logic [7:0] out_addr;
    logic       out_tile_done;

    int n_checks;
    int n_fails;
    int done_pulses;
    bit finished;

    ycc_tile_converter u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_r          (in_r),
        .in_g          (in_g),
        .in_b          (in_b),
        .out_valid     (out_valid),
        .out_y         (out_y),
        .out_cb        (out_cb),
        .out_cr        (out_cr),
        .out_addr      (out_addr),
        .out_tile_done (out_tile_done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference arithmetic taken from the requirement formulas.
    function automatic int ref_comp(input int kr, input int kg, input int kb,
                                    input int off, input int r, input int g, input int b);
        int s;
        s = kr * r + kg * g + kb * b + off * 16384 + 8192;
        s = s >>> 14;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    function automatic int ref_y(input int r, input int g, input int b);
        return ref_comp(4897, 9611, 1876, 0, r, g, b);
    endfunction
    function automatic int ref_cb(input int r, input int g, input int b);
        return ref_comp(-2764, -5426, 8192, 128, r, g, b);
    endfunction
    function automatic int ref_cr(input int r, input int g, input int b);
        return ref_comp(8192, -6853, -1337, 128, r, g, b);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Timing model: three-edge delay of the accepted pixels.
    bit       ev [3];
    int       ey [3];
    int       ecb[3];
    int       ecr[3];
    int       ea [3];
    int       bidx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                ev[i] = 1'b0; ey[i] = 0; ecb[i] = 0; ecr[i] = 0; ea[i] = 0;
            end
            bidx = 0;
        end else begin
            for (int i = 2; i > 0; i--) begin
                ev[i] = ev[i-1]; ey[i] = ey[i-1]; ecb[i] = ecb[i-1];
                ecr[i] = ecr[i-1]; ea[i] = ea[i-1];
            end
            ev[0]  = in_valid;
            ey[0]  = ref_y(in_r, in_g, in_b);
            ecb[0] = ref_cb(in_r, in_g, in_b);
            ecr[0] = ref_cr(in_r, in_g, in_b);
            ea[0]  = bidx;
            if (in_valid) bidx = (bidx + 1) % 256;
        end
    end

    // Cycle monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(out_valid == ev[2], "R5", "out_valid", out_valid, ev[2]);
            if (ev[2]) begin
                check(out_y == ey[2], "R1", "out_y", out_y, ey[2]);
                check(out_cb == ecb[2], "R2", "out_cb", out_cb, ecb[2]);
                check(out_cr == ecr[2], "R3", "out_cr", out_cr, ecr[2]);
                check(out_addr == ea[2], "R7", "out_addr", out_addr, ea[2]);
                check(out_tile_done == (ea[2] == 255), "R8", "out_tile_done",
                      out_tile_done, ea[2] == 255);
            end else begin
                check(out_tile_done == 1'b0, "R8", "out_tile_done idle", out_tile_done, 0);
            end
            if (out_tile_done) done_pulses++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_r = '0; in_g = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R6: outputs held low in reset
        check(out_valid == 1'b0, "R6", "out_valid in reset", out_valid, 0);
        check(out_tile_done == 1'b0, "R6", "out_tile_done in reset", out_tile_done, 0);
        rst_n = 1'b1;
    endtask

    // One isolated pixel; checks exact latency and hard-coded results.
    task automatic check_color(input int r, input int g, input int b,
                               input int xy, input int xcb, input int xcr, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5", "valid one edge early", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5", "valid at third edge", out_valid, 1);
        check(out_y == xy, req, "y", out_y, xy);
        check(out_cb == xcb, req, "cb", out_cb, xcb);
        check(out_cr == xcr, req, "cr", out_cr, xcr);
        @(negedge clk);
    endtask

    task automatic test_primaries();
        check_color(0, 0, 0, 0, 128, 128, "R2");
        check_color(255, 255, 255, 255, 128, 128, "R1");
        check_color(0, 255, 0, 150, 44, 21, "R3");
        check_color(255, 0, 0, 76, 85, 255, "R4");
        check_color(0, 0, 255, 29, 255, 107, "R4");
        check_color(200, 200, 200, 200, 128, 128, "R9");
    endtask

    // R7, R8: reset restarts the count; one dense tile.
    task automatic test_dense_tile();
        int pulses0;
        do_reset();
        pulses0 = done_pulses;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_r = 8'(i); in_g = 8'(255 - i); in_b = 8'((i * 7) % 256);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(done_pulses - pulses0 == 1, "R8", "tile markers dense", done_pulses - pulses0, 1);
    endtask

    // R7: idle cycles do not advance the address; second tile wraps.
    task automatic test_gapped_tile();
        int pulses0;
        pulses0 = done_pulses;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_r = 8'((i * 13) % 256); in_g = 8'((i * 5 + 40) % 256); in_b = 8'((i * 29) % 256);
            if (i % 3 == 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_r = 8'hFF; in_g = 8'h00; in_b = 8'hFF;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(done_pulses - pulses0 == 1, "R8", "tile markers gapped", done_pulses - pulses0, 1);
        check(bidx == 44, "R7", "bench count wrapped", bidx, 44);
    endtask

    initial begin
        n_checks = 0; n_fails = 0; done_pulses = 0; finished = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
        do_reset();
        test_primaries();
        test_dense_tile();
        test_gapped_tile();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", MAX_CYCLES, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule